// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox Pair

This block lets a host-bus side and a local side exchange 32-bit command and status words when each side runs on its own clock. It holds exactly two storage words. The host writes the forward word and the local side reads it. The local side writes the return word and the host reads it. The word one side writes as its outgoing mailbox is the same register the other side reads as its incoming mailbox. No copy of it is kept.

Each byte lane of each word has a full flag. A write with that lane's byte enable high sets the flag in the writer's clock domain. A read by the far side clears it in the reader's clock domain. The set and clear events cross between domains through toggle synchronizers. Every read passes through a holding register that is loaded on the read edge. A write that lands in the same cycle, or any later cycle, therefore cannot change the word being returned.

Each side has a status vector with the full flags of both mailboxes. It also has two interrupt sources, and each source is enabled separately. The incoming source fires when a chosen byte lane of the incoming mailbox becomes full. The outgoing source fires when the outgoing mailbox has been drained to fully empty. A pending interrupt stays set until the side writes a one to clear it.

Top module: `mbox_pair`

## Requirements
- R1: A word written by one side with all four byte enables high is returned unchanged by the next read on the other side. This holds in both directions.
- R2: A byte lane written with its enable low keeps its previous content. Lane i covers data bits 8i+7 down to 8i, and enable bit i gates lane i.
- R3: Read data comes from a holding register loaded on the read edge. It stays unchanged until that side's next read, even when the writer updates the mailbox in between.
- R4: Status bits [7:4] show the side's outgoing mailbox lanes and bits [3:0] show its incoming mailbox lanes, with bit i for lane i. After reset all status bits, read data and interrupts are zero. Outgoing flags for the written lanes are set in the cycle after the write.
- R5: A lane written by the far side shows as full in the incoming status within three reader clock cycles.
- R6: A read clears every incoming full flag of that mailbox in the next reader cycle. The writer's outgoing flags clear within three writer cycles after that.
- R7: A write to a lane that is already full overwrites the data and leaves the flag set. No error is raised.
- R8: When the incoming interrupt is enabled, the selected lane going from empty to full sets pending bit 0. A lane that is not selected does not set it.
- R9: When the outgoing interrupt is enabled, the outgoing flags going from any full to all empty set pending bit 1.
- R10: Pending bits hold until a one is written to the matching clear bit. A source whose enable is low never sets its pending bit. The interrupt output is the OR of the pending bits.
- R11: An incoming full flag never clears except through a read by its own side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hClk | input | 1 | Host-side clock |
| lClk | input | 1 | Local-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| hWrEn | input | 1 | Host write strobe to the forward mailbox |
| hWrBe | input | 4 | Host byte enables |
| hWrData | input | 32 | Host write data |
| hRdEn | input | 1 | Host read strobe for the return mailbox |
| hRdData | output | 32 | Host read holding register |
| hStatus | output | 8 | Host flags: [7:4] outgoing, [3:0] incoming |
| hIrqEnIn | input | 1 | Host incoming interrupt enable |
| hIrqEnOut | input | 1 | Host outgoing interrupt enable |
| hIrqSel | input | 2 | Lane that raises the host incoming interrupt |
| hIrqClr | input | 2 | Write-one-to-clear of host pending bits |
| hIrqPend | output | 2 | Host pending bits: [0] incoming, [1] outgoing |
| hIrq | output | 1 | Host interrupt request |
| lWrEn | input | 1 | Local write strobe to the return mailbox |
| lWrBe | input | 4 | Local byte enables |
| lWrData | input | 32 | Local write data |
| lRdEn | input | 1 | Local read strobe for the forward mailbox |
| lRdData | output | 32 | Local read holding register |
| lStatus | output | 8 | Local flags: [7:4] outgoing, [3:0] incoming |
| lIrqEnIn | input | 1 | Local incoming interrupt enable |
| lIrqEnOut | input | 1 | Local outgoing interrupt enable |
| lIrqSel | input | 2 | Lane that raises the local incoming interrupt |
| lIrqClr | input | 2 | Write-one-to-clear of local pending bits |
| lIrqPend | output | 2 | Local pending bits: [0] incoming, [1] outgoing |
| lIrq | output | 1 | Local interrupt request |

## Verification
The assertions assume that a writer never rewrites a lane while a clear for that lane from the far side is still crossing the synchronizer. They also assume the interrupt enables only change while no flag is moving. Under those assumptions, incoming flags fall only on a local read and outgoing flags rise on the cycle after a write. The directed tasks keep within these assumptions: after every write or read they wait six cycles of the other clock before the next access, and they set the enables between scenarios, when both mailboxes are empty.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_LANES = 4;
  localparam int LANE_W   = 8;

  typedef struct packed {
    logic [MB_LANES-1:0] hLoad;  // host lanes to store in forward word
    logic [MB_LANES-1:0] lLoad;  // local lanes to store in return word
    logic                hCap;   // host holding register capture
    logic                lCap;   // local holding register capture
  } mbStrobes_t;
endpackage

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             wClk,
  input  logic             rClk,
  input  logic             rstN,
  input  logic [LANES-1:0] setBe,
  input  logic             rdStb,
  output logic [LANES-1:0] wFull,
  output logic [LANES-1:0] rFull
);
  logic [LANES-1:0] setTog, clrTog;
  logic [LANES-1:0] setSync [STAGES];
  logic [LANES-1:0] clrSync [STAGES];

  assign wFull = setTog ^ clrSync[STAGES-1];
  assign rFull = setSync[STAGES-1] ^ clrTog;

  // writer domain: toggle only for lanes that are empty here
  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN) begin
      setTog <= '0;
      for (int i = 0; i < STAGES; i++) clrSync[i] <= '0;
    end else begin
      setTog     <= setTog ^ (setBe & ~wFull);
      clrSync[0] <= clrTog;
      for (int i = 1; i < STAGES; i++) clrSync[i] <= clrSync[i-1];
    end
  end

  // reader domain: a read retires every lane seen as full
  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN) begin
      clrTog <= '0;
      for (int i = 0; i < STAGES; i++) setSync[i] <= '0;
    end else begin
      clrTog     <= clrTog ^ (rdStb ? rFull : '0);
      setSync[0] <= setTog;
      for (int i = 1; i < STAGES; i++) setSync[i] <= setSync[i-1];
    end
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enIn,
  input  logic             enOut,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       clr,
  input  logic [LANES-1:0] inFull,
  input  logic [LANES-1:0] outFull,
  output logic [1:0]       pend
);
  logic [LANES-1:0] prevIn;
  logic             prevOutAny;
  logic             inRise, outDrain;

  assign inRise   = inFull[sel] & ~prevIn[sel];
  assign outDrain = prevOutAny & ~(|outFull);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn     <= '0;
      prevOutAny <= 1'b0;
      pend       <= '0;
    end else begin
      prevIn     <= inFull;
      prevOutAny <= |outFull;
      pend[0]    <= (pend[0] & ~clr[0]) | (enIn & inRise);
      pend[1]    <= (pend[1] & ~clr[1]) | (enOut & outDrain);
    end
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int LANES = MB_LANES,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic             hClk,
  input  logic             lClk,
  input  logic             rstN,
  input  logic             hWrEn,
  input  logic [LANES-1:0] hWrBe,
  input  logic             hRdEn,
  input  logic             hIrqEnIn,
  input  logic             hIrqEnOut,
  input  logic [SEL_W-1:0] hIrqSel,
  input  logic [1:0]       hIrqClr,
  input  logic             lWrEn,
  input  logic [LANES-1:0] lWrBe,
  input  logic             lRdEn,
  input  logic             lIrqEnIn,
  input  logic             lIrqEnOut,
  input  logic [SEL_W-1:0] lIrqSel,
  input  logic [1:0]       lIrqClr,
  output mbStrobes_t       stb,
  output logic [2*LANES-1:0] hStatus,
  output logic [2*LANES-1:0] lStatus,
  output logic [1:0]       hIrqPend,
  output logic [1:0]       lIrqPend
);
  logic [LANES-1:0] fwdW, fwdR, retW, retR;

  assign stb.hLoad = hWrEn ? hWrBe : '0;
  assign stb.lLoad = lWrEn ? lWrBe : '0;
  assign stb.hCap  = hRdEn;
  assign stb.lCap  = lRdEn;

  // forward word: host writes, local reads
  mbox_flags #(.LANES(LANES), .STAGES(SYNC_STAGES)) fwdFlags (
    .wClk(hClk), .rClk(lClk), .rstN(rstN),
    .setBe(stb.hLoad), .rdStb(lRdEn),
    .wFull(fwdW), .rFull(fwdR)
  );

  // return word: local writes, host reads
  mbox_flags #(.LANES(LANES), .STAGES(SYNC_STAGES)) retFlags (
    .wClk(lClk), .rClk(hClk), .rstN(rstN),
    .setBe(stb.lLoad), .rdStb(hRdEn),
    .wFull(retW), .rFull(retR)
  );

  assign hStatus = {fwdW, retR};
  assign lStatus = {retW, fwdR};

  mbox_irq #(.LANES(LANES)) hostIrq (
    .clk(hClk), .rstN(rstN), .enIn(hIrqEnIn), .enOut(hIrqEnOut),
    .sel(hIrqSel), .clr(hIrqClr), .inFull(retR), .outFull(fwdW),
    .pend(hIrqPend)
  );

  mbox_irq #(.LANES(LANES)) localIrq (
    .clk(lClk), .rstN(rstN), .enIn(lIrqEnIn), .enOut(lIrqEnOut),
    .sel(lIrqSel), .clr(lIrqClr), .inFull(fwdR), .outFull(retW),
    .pend(lIrqPend)
  );
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  localparam int LANES  = MB_LANES,
  localparam int DATA_W = MB_LANES * LANE_W
) (
  input  logic              hClk,
  input  logic              lClk,
  input  logic              rstN,
  input  mbStrobes_t        stb,
  input  logic [DATA_W-1:0] hWrData,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] hRdData,
  output logic [DATA_W-1:0] lRdData
);
  logic [DATA_W-1:0] fwdWord, retWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge hClk or negedge rstN) begin
      if (!rstN)              fwdWord[g*LANE_W +: LANE_W] <= '0;
      else if (stb.hLoad[g])  fwdWord[g*LANE_W +: LANE_W] <= hWrData[g*LANE_W +: LANE_W];
    end
    always_ff @(posedge lClk or negedge rstN) begin
      if (!rstN)              retWord[g*LANE_W +: LANE_W] <= '0;
      else if (stb.lLoad[g])  retWord[g*LANE_W +: LANE_W] <= lWrData[g*LANE_W +: LANE_W];
    end
  end

  // holding registers: snapshot on the read edge
  always_ff @(posedge hClk or negedge rstN) begin
    if (!rstN)         hRdData <= '0;
    else if (stb.hCap) hRdData <= retWord;
  end

  always_ff @(posedge lClk or negedge rstN) begin
    if (!rstN)         lRdData <= '0;
    else if (stb.lCap) lRdData <= fwdWord;
  end
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int LANES  = MB_LANES,
  localparam int DATA_W = MB_LANES * LANE_W,
  localparam int SEL_W  = $clog2(MB_LANES)
) (
  input  logic               hClk,
  input  logic               lClk,
  input  logic               rstN,
  input  logic               hWrEn,
  input  logic [LANES-1:0]   hWrBe,
  input  logic [DATA_W-1:0]  hWrData,
  input  logic               hRdEn,
  output logic [DATA_W-1:0]  hRdData,
  output logic [2*LANES-1:0] hStatus,
  input  logic               hIrqEnIn,
  input  logic               hIrqEnOut,
  input  logic [SEL_W-1:0]   hIrqSel,
  input  logic [1:0]         hIrqClr,
  output logic [1:0]         hIrqPend,
  output logic               hIrq,
  input  logic               lWrEn,
  input  logic [LANES-1:0]   lWrBe,
  input  logic [DATA_W-1:0]  lWrData,
  input  logic               lRdEn,
  output logic [DATA_W-1:0]  lRdData,
  output logic [2*LANES-1:0] lStatus,
  input  logic               lIrqEnIn,
  input  logic               lIrqEnOut,
  input  logic [SEL_W-1:0]   lIrqSel,
  input  logic [1:0]         lIrqClr,
  output logic [1:0]         lIrqPend,
  output logic               lIrq
);
  mbStrobes_t stb;

  mbox_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl (
    .hClk(hClk), .lClk(lClk), .rstN(rstN),
    .hWrEn(hWrEn), .hWrBe(hWrBe), .hRdEn(hRdEn),
    .hIrqEnIn(hIrqEnIn), .hIrqEnOut(hIrqEnOut), .hIrqSel(hIrqSel), .hIrqClr(hIrqClr),
    .lWrEn(lWrEn), .lWrBe(lWrBe), .lRdEn(lRdEn),
    .lIrqEnIn(lIrqEnIn), .lIrqEnOut(lIrqEnOut), .lIrqSel(lIrqSel), .lIrqClr(lIrqClr),
    .stb(stb), .hStatus(hStatus), .lStatus(lStatus),
    .hIrqPend(hIrqPend), .lIrqPend(lIrqPend)
  );

  mbox_dp dp (
    .hClk(hClk), .lClk(lClk), .rstN(rstN), .stb(stb),
    .hWrData(hWrData), .lWrData(lWrData),
    .hRdData(hRdData), .lRdData(lRdData)
  );

  assign hIrq = |hIrqPend;
  assign lIrq = |lIrqPend;
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 32
) (
  input logic               hClk,
  input logic               lClk,
  input logic               rstN,
  input logic               hWrEn,
  input logic [LANES-1:0]   hWrBe,
  input logic               hRdEn,
  input logic [DATA_W-1:0]  hRdData,
  input logic [2*LANES-1:0] hStatus,
  input logic               hIrqEnIn,
  input logic               hIrqEnOut,
  input logic               hIrq,
  input logic               lRdEn,
  input logic [DATA_W-1:0]  lRdData,
  input logic [2*LANES-1:0] lStatus
);
  logic [LANES-1:0] hFresh;
  assign hFresh = (hWrEn ? hWrBe : '0) & ~hStatus[2*LANES-1:LANES];

  AST_HOLD_LOCAL_READ: assert property (@(posedge lClk) disable iff (!rstN)
    !lRdEn |=> $stable(lRdData)); // R3

  AST_HOLD_HOST_READ: assert property (@(posedge hClk) disable iff (!rstN)
    !hRdEn |=> $stable(hRdData)); // R3

  AST_OUT_FLAG_SET: assert property (@(posedge hClk) disable iff (!rstN)
    (hFresh != '0) |=> ((hStatus[2*LANES-1:LANES] & $past(hFresh)) == $past(hFresh))); // R4

  AST_IN_FLAG_KEPT: assert property (@(posedge lClk) disable iff (!rstN)
    !lRdEn |=> ((lStatus[LANES-1:0] & $past(lStatus[LANES-1:0])) == $past(lStatus[LANES-1:0]))); // R11

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge hClk) disable iff (!rstN)
    $rose(hIrq) |-> $past(hIrqEnIn | hIrqEnOut)); // R10
endmodule

bind mbox_pair mbox_pair_chk #(.LANES(mbox_pkg::MB_LANES), .DATA_W(mbox_pkg::MB_LANES * mbox_pkg::LANE_W)) chkInst (
  .hClk(hClk), .lClk(lClk), .rstN(rstN),
  .hWrEn(hWrEn), .hWrBe(hWrBe), .hRdEn(hRdEn), .hRdData(hRdData), .hStatus(hStatus),
  .hIrqEnIn(hIrqEnIn), .hIrqEnOut(hIrqEnOut), .hIrq(hIrq),
  .lRdEn(lRdEn), .lRdData(lRdData), .lStatus(lStatus)
);

// File: tb/tb_mbox_pair.sv
module tb_mbox_pair;
  logic hClk = 0, lClk = 0, rstN = 0;
  logic hWrEn = 0, hRdEn = 0, lWrEn = 0, lRdEn = 0;
  logic [3:0] hWrBe = 0, lWrBe = 0;
  logic [31:0] hWrData = 0, lWrData = 0;
  logic hIrqEnIn = 0, hIrqEnOut = 0, lIrqEnIn = 0, lIrqEnOut = 0;
  logic [1:0] hIrqSel = 0, lIrqSel = 0, hIrqClr = 0, lIrqClr = 0;
  logic [31:0] hRdData, lRdData;
  logic [7:0] hStatus, lStatus;
  logic [1:0] hIrqPend, lIrqPend;
  logic hIrq, lIrq;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 hClk = ~hClk;  // 200 MHz host clock
  always #3.5 lClk = ~lClk;  // unrelated local clock

  mbox_pair dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hWrite(input logic [31:0] d, input logic [3:0] be);
    @(negedge hClk); hWrEn = 1; hWrBe = be; hWrData = d;
    @(negedge hClk); hWrEn = 0; hWrBe = 0;
  endtask
  task automatic lWrite(input logic [31:0] d, input logic [3:0] be);
    @(negedge lClk); lWrEn = 1; lWrBe = be; lWrData = d;
    @(negedge lClk); lWrEn = 0; lWrBe = 0;
  endtask
  task automatic hRead();
    @(negedge hClk); hRdEn = 1;
    @(negedge hClk); hRdEn = 0;
  endtask
  task automatic lRead();
    @(negedge lClk); lRdEn = 1;
    @(negedge lClk); lRdEn = 0;
  endtask
  task automatic settleL(); repeat (6) @(negedge lClk); endtask
  task automatic settleH(); repeat (6) @(negedge hClk); endtask

  task automatic tReset();
    check("R4 reset host status", {24'h0, hStatus}, 32'h0);
    check("R4 reset local status", {24'h0, lStatus}, 32'h0);
    check("R4 reset read data", lRdData | hRdData, 32'h0);
    check("R4 reset irq", {30'h0, hIrq, lIrq}, 32'h0);
  endtask

  task automatic tForward();
    hWrite(32'hA5A5_1234, 4'hF);
    check("R4 host outgoing flags", {28'h0, hStatus[7:4]}, 32'hF);
    settleL();
    check("R5 local incoming flags", {28'h0, lStatus[3:0]}, 32'hF);
    lRead();
    check("R1 forward data", lRdData, 32'hA5A5_1234);
    check("R6 local flags cleared", {28'h0, lStatus[3:0]}, 32'h0);
    settleH();
    check("R6 host flags cleared", {28'h0, hStatus[7:4]}, 32'h0);
  endtask

  task automatic tPartial();
    hWrite(32'h1122_3344, 4'hF); settleL(); lRead(); settleH();
    hWrite(32'hAABB_CCDD, 4'b0101);
    check("R4 partial outgoing flags", {28'h0, hStatus[7:4]}, 32'h5);
    settleL();
    check("R5 partial incoming flags", {28'h0, lStatus[3:0]}, 32'h5);
    lRead();
    check("R2 masked lanes kept", lRdData, 32'h11BB_33DD);
    settleH();
  endtask

  task automatic tReturn();
    lWrite(32'hCAFE_F00D, 4'hF);
    check("R4 local outgoing flags", {28'h0, lStatus[7:4]}, 32'hF);
    settleH();
    check("R5 host incoming flags", {28'h0, hStatus[3:0]}, 32'hF);
    hRead();
    check("R1 return data", hRdData, 32'hCAFE_F00D);
    check("R6 host incoming cleared", {28'h0, hStatus[3:0]}, 32'h0);
    settleL();
    check("R6 local outgoing cleared", {28'h0, lStatus[7:4]}, 32'h0);
  endtask

  task automatic tInterlock();
    hWrite(32'h0000_0001, 4'hF); settleL(); lRead();
    check("R3 first snapshot", lRdData, 32'h1);
    settleH();
    hWrite(32'h0000_0002, 4'hF); settleL();
    check("R3 snapshot held across write", lRdData, 32'h1);
    lRead();
    check("R3 next read updates", lRdData, 32'h2);
    settleH();
  endtask

  task automatic tOverwrite();
    hWrite(32'h1111_1111, 4'hF); settleL();
    hWrite(32'h2222_2222, 4'hF);
    check("R7 flag stays after overwrite", {28'h0, hStatus[7:4]}, 32'hF);
    settleL();
    check("R7 local still full", {28'h0, lStatus[3:0]}, 32'hF);
    lRead();
    check("R7 newest data wins", lRdData, 32'h2222_2222);
    settleH();
    check("R7 cleared after read", {28'h0, hStatus[7:4]}, 32'h0);
  endtask

  task automatic tIrqIn();
    @(negedge lClk); lIrqEnIn = 1; lIrqSel = 2;
    hWrite(32'h0, 4'b0001); settleL();
    check("R8 other lane no irq", {31'h0, lIrq}, 32'h0);
    hWrite(32'h0, 4'b0100); settleL();
    check("R8 selected lane irq", {30'h0, lIrqPend}, 32'h1);
    lRead(); settleL();
    check("R10 pending holds", {31'h0, lIrq}, 32'h1);
    check("R10 disabled host no irq", {31'h0, hIrq}, 32'h0);
    @(negedge lClk); lIrqClr = 2'b01;
    @(negedge lClk); lIrqClr = 2'b00;
    check("R10 w1c clears", {31'h0, lIrq}, 32'h0);
    @(negedge lClk); lIrqEnIn = 0;
    settleH();
  endtask

  task automatic tIrqOut();
    @(negedge hClk); hIrqEnOut = 1;
    hWrite(32'h5, 4'hF); settleH();
    check("R9 no irq while full", {31'h0, hIrq}, 32'h0);
    lRead(); settleH();
    check("R9 drain irq", {30'h0, hIrqPend}, 32'h2);
    @(negedge hClk); hIrqClr = 2'b10;
    @(negedge hClk); hIrqClr = 2'b00;
    check("R10 out w1c clears", {31'h0, hIrq}, 32'h0);
    hIrqEnOut = 0;
  endtask

  initial begin
    repeat (3) @(negedge hClk);
    tReset();
    rstN = 1;
    repeat (3) @(negedge lClk);
    tForward();
    tPartial();
    tReturn();
    tInterlock();
    tOverwrite();
    tIrqIn();
    tIrqOut();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #200us;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule